// File: doc/BRIEF.md
# Trigger Message Decoder for a Symbol Link

The block takes a stream of link symbols that a line receiver has already recovered. Each symbol is a 4-bit index from 0 to 8 and comes with a one-cycle strobe. From this stream the block builds trigger messages.

Indices 0 to 7 are data symbols, and each one carries three bits. Index 8 is the single control symbol. It marks end-of-transfer and is also used as idle. An idle line sends index 8 and index 7 in turn. A message begins with two identifier symbols, and the first of them must lie in 0..6. Twenty-two payload symbols follow the identifier and give a 64-bit trigger payload. When a message completes, the decoder presents the trigger number and the payload together with a one-cycle valid pulse. A malformed or cut-off message gives a one-cycle error pulse instead.

The control symbol always sends the decoder back to idle. For this reason, a corrupt transfer cannot affect anything after the next control symbol.

Top module: `trig_sym_decoder`

## Requirements
- R1: After a synchronous active-low reset, `trig_valid`, `frame_err`, `trig_num` and `trig_payload` are all zero and the decoder is idle.
- R2: Index values 0..7 are data symbols carrying 3 bits each, and index 8 is the control symbol. A cycle with `sym_valid` low has no effect, and it produces neither a valid pulse nor an error pulse in the next cycle.
- R3: Index 8 returns the decoder to idle from any state. The next data symbol is then treated as the first identifier symbol.
- R4: While idle, index 7 is ignored and does not start a message. Only indices 0..6 start one.
- R5: The trigger number is first*8 + second, where first is the first identifier symbol (0..6) and second is the second identifier symbol (0..7). The number therefore lies in 0..55.
- R6: The 22 symbols after the identifier are joined MSB-first into a 66-bit value. `trig_payload` is its low 64 bits. `trig_valid` is high for exactly one cycle, the cycle after the 22nd payload symbol is strobed in. `trig_num` and `trig_payload` keep their values until the next valid pulse.
- R7: If the top two bits of the 66-bit value are not both zero, no valid pulse is given. Instead `frame_err` pulses for one cycle, and the outputs keep their old values.
- R8: If index 8 arrives after the first identifier symbol but before the 22nd payload symbol, `frame_err` pulses in the next cycle and the message is dropped.
- R9: After a message completes, a data symbol that arrives before index 8 raises one `frame_err` pulse. Any further data symbols before index 8 are ignored silently.
- R10: Index values 9..15 are invalid. Outside the discard state, each one raises one `frame_err` pulse, and the decoder then discards all symbols until index 8 arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | Strobe: `sym_code` holds a symbol this cycle |
| sym_code | input | 4 | Symbol index (0..7 data, 8 control, 9..15 invalid) |
| trig_valid | output | 1 | One-cycle pulse when a trigger message is complete |
| trig_num | output | 6 | Trigger number 0..55 |
| trig_payload | output | 64 | Trigger payload |
| frame_err | output | 1 | One-cycle pulse for a malformed or aborted message |

## Verification
All results are registered, so each is due exactly one cycle after the clock edge that takes in the symbol which causes it. This covers the valid pulse after the 22nd payload symbol, the error pulse after an early control symbol, an extra symbol or an invalid code, and the quiet cycle after a gap in the strobe. The bench drives one symbol per cycle on the falling edge. Its behavioural model advances on the next rising edge, and the bench compares every output on the following falling edge. As a result, each comparison lands in the single cycle in which that result is due, and the held outputs are checked in every other cycle.

// File: rtl/trig_dec_pkg.sv
// Package: protocol constants and the decoder state type.
// Assumes 3-bit data symbols with one control code directly above the data codes.
package trig_dec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a start symbol
        ST_ID   = 3'd1,   // first identifier symbol held
        ST_PAY  = 3'd2,   // collecting payload symbols
        ST_DONE = 3'd3,   // message complete, expecting control symbol
        ST_DROP = 3'd4    // discarding until control symbol
    } dec_state_t;

    // Number of symbols needed to carry `bits` at `per` bits each.
    function automatic int sym_count(input int bits, input int per);
        return (bits + per - 1) / per;
    endfunction

endpackage

// File: rtl/sym_classify.sv
// Symbol classifier: sorts one strobed symbol index into data, control,
// start-capable data and invalid. Purely combinational.
// Assumes the control code is 2**DATA_BITS and the code just below it is the
// idle filler that may not start a message.
module sym_classify #(
    parameter int DATA_BITS = 3,
    localparam int SYM_W    = DATA_BITS + 1
) (
    input  logic                 sym_valid,
    input  logic [SYM_W-1:0]     sym_code,
    output logic                 take_data,
    output logic                 take_start,
    output logic                 take_idle,
    output logic                 take_bad,
    output logic [DATA_BITS-1:0] data_bits
);
    localparam logic [SYM_W-1:0] CTRL_CODE   = SYM_W'(2 ** DATA_BITS);
    localparam logic [SYM_W-1:0] FILLER_CODE = SYM_W'(2 ** DATA_BITS - 1);

    // Decode the code range into the four classes.
    always_comb begin
        take_data  = sym_valid && (sym_code < CTRL_CODE);
        take_idle  = sym_valid && (sym_code == CTRL_CODE);
        take_bad   = sym_valid && (sym_code > CTRL_CODE);
        take_start = take_data && (sym_code != FILLER_CODE);
        data_bits  = sym_code[DATA_BITS-1:0];
    end

endmodule

// File: rtl/payload_shift.sv
// Payload shifter: MSB-first shift register of NSYM symbols. Its combinational
// next value lets the top module judge the full word in the same cycle the
// last symbol arrives.
// Assumes exactly NSYM shifts per message, so older content leaves the register
// on its own and no clear is needed.
module payload_shift #(
    parameter int DATA_BITS = 3,
    parameter int NSYM      = 22,
    localparam int ACC_W    = NSYM * DATA_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic [DATA_BITS-1:0] din,
    output logic [ACC_W-1:0]     acc_next
);
    logic [ACC_W-1:0] acc_q;

    // Value the register holds after a shift by one symbol.
    always_comb acc_next = {acc_q[ACC_W-DATA_BITS-1:0], din};

    // Shift the register on every accepted payload symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (shift_en) acc_q <= acc_next;
    end

endmodule

// File: rtl/frame_ctrl.sv
// Frame controller: tracks the message phase and counts payload symbols. It
// issues one-cycle events for the datapath and for protocol errors.
// Assumes the classes from sym_classify are mutually exclusive.
module frame_ctrl
    import trig_dec_pkg::*;
#(
    parameter int NSYM    = 22,
    localparam int CNT_W  = $clog2(NSYM + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take_data,
    input  logic       take_start,
    input  logic       take_idle,
    input  logic       take_bad,
    output dec_state_t state,
    output logic       ev_first,
    output logic       ev_second,
    output logic       ev_shift,
    output logic       ev_complete,
    output logic       ev_err
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NSYM - 1);

    dec_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;

    // Next phase and the events it implies.
    always_comb begin
        state_d     = state;
        ev_first    = 1'b0;
        ev_second   = 1'b0;
        ev_shift    = 1'b0;
        ev_complete = 1'b0;
        ev_err      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (take_start) begin
                    ev_first = 1'b1;
                    state_d  = ST_ID;
                end else if (take_bad) begin
                    ev_err  = 1'b1;
                    state_d = ST_DROP;
                end
            end
            ST_ID: begin
                if (take_idle) begin
                    ev_err  = 1'b1;
                    state_d = ST_IDLE;
                end else if (take_data) begin
                    ev_second = 1'b1;
                    state_d   = ST_PAY;
                end else if (take_bad) begin
                    ev_err  = 1'b1;
                    state_d = ST_DROP;
                end
            end
            ST_PAY: begin
                if (take_idle) begin
                    ev_err  = 1'b1;
                    state_d = ST_IDLE;
                end else if (take_data) begin
                    ev_shift = 1'b1;
                    if (cnt_q == LAST_IDX) begin
                        ev_complete = 1'b1;
                        state_d     = ST_DONE;
                    end
                end else if (take_bad) begin
                    ev_err  = 1'b1;
                    state_d = ST_DROP;
                end
            end
            ST_DONE: begin
                if (take_idle) begin
                    state_d = ST_IDLE;
                end else if (take_data || take_bad) begin
                    ev_err  = 1'b1;
                    state_d = ST_DROP;
                end
            end
            ST_DROP: begin
                if (take_idle) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Payload symbol counter, restarted by the second identifier symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (ev_second) cnt_q <= '0;
        else if (ev_shift)  cnt_q <= cnt_q + 1'b1;
    end

    // The control symbol always lands in idle.
    assert_ctrl_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_idle |=> (state == ST_IDLE));

    // The filler code never starts a message.
    assert_filler_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && take_data && !take_start) |=> (state == ST_IDLE));

    // The counter never passes the symbol count.
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NSYM));

    // An invalid code outside discard always leads to discard.
    assert_bad_to_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_bad && state != ST_DROP) |=> (state == ST_DROP));

endmodule

// File: rtl/trig_sym_decoder.sv
// Trigger message decoder: joins strobed link symbols into trigger messages
// (two identifier symbols, then payload symbols) and gives a number and a
// payload with a valid pulse, or an error pulse for a bad message.
// Assumes at most one symbol per cycle; every output is registered.
module trig_sym_decoder
    import trig_dec_pkg::*;
#(
    parameter int DATA_BITS  = 3,
    parameter int PAYLOAD_W  = 64,
    localparam int SYM_W     = DATA_BITS + 1,
    localparam int TRIG_W    = 2 * DATA_BITS,
    localparam int NSYM      = sym_count(PAYLOAD_W, DATA_BITS),
    localparam int ACC_W     = NSYM * DATA_BITS,
    localparam int EXCESS    = ACC_W - PAYLOAD_W,
    localparam int NUM_TRIG  = (2 ** DATA_BITS - 1) * (2 ** DATA_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sym_valid,
    input  logic [SYM_W-1:0]     sym_code,
    output logic                 trig_valid,
    output logic [TRIG_W-1:0]    trig_num,
    output logic [PAYLOAD_W-1:0] trig_payload,
    output logic                 frame_err
);
    logic                 take_data, take_start, take_idle, take_bad;
    logic [DATA_BITS-1:0] data_bits;
    dec_state_t           state;
    logic                 ev_first, ev_second, ev_shift, ev_complete, ev_err;
    logic [ACC_W-1:0]     acc_next;
    logic                 overflow;
    logic                 valid_d, err_d;
    logic [DATA_BITS-1:0] first_q;
    logic [TRIG_W-1:0]    num_pend_q;

    sym_classify #(.DATA_BITS(DATA_BITS)) u_classify (
        .sym_valid (sym_valid),
        .sym_code  (sym_code),
        .take_data (take_data),
        .take_start(take_start),
        .take_idle (take_idle),
        .take_bad  (take_bad),
        .data_bits (data_bits)
    );

    frame_ctrl #(.NSYM(NSYM)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_data  (take_data),
        .take_start (take_start),
        .take_idle  (take_idle),
        .take_bad   (take_bad),
        .state      (state),
        .ev_first   (ev_first),
        .ev_second  (ev_second),
        .ev_shift   (ev_shift),
        .ev_complete(ev_complete),
        .ev_err     (ev_err)
    );

    payload_shift #(.DATA_BITS(DATA_BITS), .NSYM(NSYM)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(ev_shift),
        .din     (data_bits),
        .acc_next(acc_next)
    );

    // Excess top bits must be clear; this check exists only when there are any.
    generate
        if (EXCESS > 0) begin : g_excess
            assign overflow = |acc_next[ACC_W-1:PAYLOAD_W];
        end else begin : g_exact
            assign overflow = 1'b0;
        end
    endgenerate

    // Completion outcome for this cycle.
    always_comb begin
        valid_d = ev_complete && !overflow;
        err_d   = ev_err || (ev_complete && overflow);
    end

    // Identifier capture: the first symbol, then the assembled number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q    <= '0;
            num_pend_q <= '0;
        end else begin
            if (ev_first)  first_q    <= data_bits;
            if (ev_second) num_pend_q <= {first_q, data_bits};
        end
    end

    // Output registers: pulses every cycle, held results on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_valid   <= 1'b0;
            frame_err    <= 1'b0;
            trig_num     <= '0;
            trig_payload <= '0;
        end else begin
            trig_valid <= valid_d;
            frame_err  <= err_d;
            if (valid_d) begin
                trig_num     <= num_pend_q;
                trig_payload <= acc_next[PAYLOAD_W-1:0];
            end
        end
    end

    // With no strobe there is nothing to report in the next cycle.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> (!trig_valid && !frame_err));

    // A delivered number is always in range.
    assert_num_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> (int'(trig_num) < NUM_TRIG));

    // The valid pulse lasts exactly one cycle.
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |=> !trig_valid);

    // A message is either delivered or flagged, never both.
    assert_valid_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_valid && frame_err));

    // Held results do not move without a valid pulse.
    assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_valid |-> ($stable(trig_num) && $stable(trig_payload)));

endmodule

// File: tb/trig_sym_decoder_bench.sv
// Bench: drives symbols on the falling edge, advances a behavioural model on the
// rising edge and compares all outputs on the next falling edge.
module trig_sym_decoder_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [3:0]  sym_code = 4'd0;
    logic        trig_valid;
    logic [5:0]  trig_num;
    logic [63:0] trig_payload;
    logic        frame_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trig_sym_decoder u_trig_sym_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_valid   (sym_valid),
        .sym_code    (sym_code),
        .trig_valid  (trig_valid),
        .trig_num    (trig_num),
        .trig_payload(trig_payload),
        .frame_err   (frame_err)
    );

    // Model state: 0 idle, 1 first id, 2 payload, 3 complete, 4 discard.
    int          m_st = 0;
    int          m_first = 0;
    int          m_num = 0;
    int          m_syms[$];
    bit          e_valid = 0;
    bit          e_err = 0;
    int          e_num = 0;
    logic [63:0] e_pay = '0;
    string       e_tag = "R1";

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one accepted clock edge.
    task automatic model(input bit v, input int c);
        logic [65:0] full;
        e_valid = 0;
        e_err   = 0;
        e_tag   = "R2";
        if (!v) return;
        if (c == 8) e_tag = "R3";
        if (c > 8) begin
            e_tag = "R10";
            if (m_st != 4) e_err = 1;
            m_st = 4;
            return;
        end
        case (m_st)
            0: begin
                if (c == 7) e_tag = "R4";
                else if (c < 7) begin m_first = c; m_st = 1; end
            end
            1: begin
                if (c == 8) begin e_err = 1; e_tag = "R8"; m_st = 0; end
                else begin m_num = m_first * 8 + c; m_syms.delete(); m_st = 2; end
            end
            2: begin
                if (c == 8) begin e_err = 1; e_tag = "R8"; m_st = 0; end
                else begin
                    m_syms.push_back(c);
                    if (m_syms.size() == 22) begin
                        full = '0;
                        foreach (m_syms[i]) full = (full << 3) | 66'(m_syms[i]);
                        m_st = 3;
                        if (full[65:64] != 2'b00) begin e_err = 1; e_tag = "R7"; end
                        else begin e_valid = 1; e_tag = "R6"; e_num = m_num; e_pay = full[63:0]; end
                    end
                end
            end
            3: begin
                if (c == 8) m_st = 0;
                else begin e_err = 1; e_tag = "R9"; m_st = 4; end
            end
            default: begin
                if (c == 8) m_st = 0;
                else e_tag = "R9";
            end
        endcase
    endtask

    task automatic compare();
        check(e_tag, "trig_valid", longint'(trig_valid), longint'(e_valid));
        check(e_tag, "frame_err", longint'(frame_err), longint'(e_err));
        check("R5", "trig_num", longint'(trig_num), longint'(e_num));
        check("R6", "trig_payload", longint'(trig_payload), longint'(e_pay));
    endtask

    task automatic step(input bit v, input int c);
        sym_valid = v;
        sym_code  = 4'(c);
        @(posedge clk);
        model(v, c);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sym_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; e_valid = 0; e_err = 0; e_num = 0; e_pay = '0; e_tag = "R1";
        compare();
    endtask

    // Sends id pair then 22 payload symbols from {top2, pay}; gap inserts dead cycles.
    task automatic send_msg(input int a, input int b, input logic [1:0] top2,
                            input logic [63:0] pay, input bit gap);
        logic [65:0] full;
        full = {top2, pay};
        step(1, a);
        step(1, b);
        for (int i = 21; i >= 0; i--) begin
            step(1, int'(full[i*3 +: 3]));
            if (gap && (i % 5 == 0)) step(0, 3);
        end
    endtask

    task automatic idle_pair();
        step(1, 8);
        step(1, 7);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();                                  // R1 reset values
        for (int i = 0; i < 3; i++) idle_pair();     // R4 filler ignored
        send_msg(0, 0, 2'b00, 64'h0123_4567_89AB_CDEF, 0);   // R5 lowest number
        step(1, 8);
        send_msg(6, 7, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 0);   // R5 highest number 55
        idle_pair();
        send_msg(3, 5, 2'b00, 64'hDEAD_BEEF_0000_0001, 1);   // R2 strobe gaps
        step(1, 8);
        send_msg(2, 1, 2'b10, 64'h1111_2222_3333_4444, 0);   // R7 excess bits
        step(1, 8);
        send_msg(1, 4, 2'b01, 64'h0, 0);                     // R7 excess bits
        idle_pair();
        step(1, 5); step(1, 8);                              // R8 abort after first id
        step(1, 2); step(1, 3); step(1, 6); step(1, 1); step(1, 8);  // R8 abort in payload
        send_msg(4, 2, 2'b00, 64'hA5A5_5A5A_C3C3_3C3C, 0);
        step(1, 3); step(1, 4); step(0, 0); step(1, 7);      // R9 extra symbols
        step(1, 8);
        step(1, 12); step(1, 2); step(1, 15); step(1, 8);    // R10 invalid in idle
        step(1, 5); step(1, 1); step(1, 9); step(1, 4); step(1, 8);  // R10 invalid mid message
        send_msg(5, 6, 2'b00, 64'h8000_0000_0000_0000, 0);
        step(1, 10);                                          // R10 after completion
        step(1, 8);
        step(1, 1); step(1, 2);
        do_reset();                                           // R1 reset mid message
        step(1, 0);                                           // R3 fresh start after reset
        send_msg(6, 0, 2'b00, 64'h0000_0000_FFFF_0000, 0);
        idle_pair();
        for (int k = 0; k < 4; k++) begin                     // R6 computed patterns
            logic [63:0] p;
            p = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 3);
            send_msg(k % 7, (k * 3) % 8, 2'b00, p, k[0]);
            step(1, 8);
        end
        step(0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule